// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Controller

This block sits next to a UART receiver and decides, character by character, whether a received character reaches the rest of the system. When the receiver is muted, characters are dropped silently. The receive-ready strobe is gated, so no interrupt or DMA request follows from a dropped character. Software mutes the receiver with a one-cycle request. The block then wakes it by one of two methods, picked by a mode input: either the line going quiet for a whole idle frame, or the arrival of an address character that carries this node's address.

The receiver front end supplies a strobe with each completed character, the serial line level and a one-per-bit-time tick. From the line level and the tick, the block measures idle frames itself. An idle frame lasts as long as one whole character: start bit, data bits and stop bit. In address mode, the top data bit marks a character as an address. The block compares either the four low bits or a long field with its own address. The width of the long field follows the character length.

All three outputs are registered and change one clock after the input event that causes them.

Top module: `rx_mute_ctrl`

## Requirements
- R1: After reset, `mute` is 0 and `rx_ready` and `idle_flag` are both 0.
- R2: With `wake_sel`=0 (idle wakeup), a `mute_req` pulse sets `mute` on the next clock, provided the line is not already quiet.
- R3: With `wake_sel`=0, an idle frame detected while `mute`=1 clears `mute` and does not raise `idle_flag`. An idle frame detected while `mute`=0, or in address mode, raises `idle_flag` for one cycle.
- R4: With `wake_sel`=0, a `mute_req` that arrives after an idle frame has been detected, with no character or low line level since then, is ignored and `mute` stays 0.
- R5: An idle frame is declared after N+2 `bit_tick` pulses with `rx_line` high, where N is the character length. No character is needed first after reset. After each detection, a new character is needed before the next idle frame can be declared.
- R6: `data_len` encodes the character length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits. With `wake_sel`=1, a character whose top bit is 1 (bit 6, 7 or 8 respectively) is an address. Any other character is data.
- R7: With `addr_long`=0, an address matches when `char_data[3:0]` equals `own_addr[3:0]`. With `addr_long`=1, it matches on bits [5:0], [6:0] or [7:0] for 7-, 8- or 9-bit characters.
- R8: With `wake_sel`=1, an address character that does not match sets `mute`, and no `rx_ready` pulse is given for it.
- R9: With `wake_sel`=1, a matching address character clears `mute` and is itself delivered with an `rx_ready` pulse.
- R10: A data character received while `mute`=1 gives no `rx_ready` pulse. While `mute`=0, it gives a one-cycle `rx_ready` pulse one clock after `char_valid`.
- R11: With `wake_sel`=1, `mute_req` always sets `mute`. When `mute_req` and a matching address character arrive in the same cycle, the wakeup wins and `mute` ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address character |
| data_len | input | 2 | Character length code (0: 7, 1: 8, 2: 9 bits) |
| addr_long | input | 1 | 1 selects the long address compare, 0 the 4-bit compare |
| own_addr | input | 8 | Address of this node |
| mute_req | input | 1 | One-cycle request to enter mute |
| rx_line | input | 1 | Serial line level, high when idle |
| bit_tick | input | 1 | One pulse per bit time |
| char_valid | input | 1 | One-cycle strobe: a character has been received |
| char_data | input | 9 | Received character, right-aligned |
| mute | output | 1 | Receiver mute status |
| rx_ready | output | 1 | Gated one-cycle receive-ready strobe |
| idle_flag | output | 1 | One-cycle idle frame indication |

## Verification
The bench targets the narrow cases. One is a mute request that lands after the line has already gone quiet: a careless design would mute there and never wake. Another is an idle frame that ends mute, which a wrong design would also report through `idle_flag`. The bench checks the start-up idle frame, which needs no prior character, and the tick count one short of a frame, which would expose an off-by-one timer. It sends characters whose top bit sits one position above or below the selected length, so a fixed-position address decode is caught. It exercises the long compares for 7- and 9-bit characters, where a fixed 7-bit compare would misjudge them. It sends a mute request in the same cycle as a matching address, where reversed priority would leave the node asleep. Random sequences are checked against a model in the bench.

// File: rtl/rx_mute_pkg.sv
package rx_mute_pkg;

    localparam int CHAR_W = 9;
    localparam int ADDR_W = 8;
    localparam int TICK_W = 4;

    typedef enum logic {
        WAKE_ON_IDLE = 1'b0,
        WAKE_ON_ADDR = 1'b1
    } wake_mode_e;

    typedef enum logic [1:0] {
        LEN7 = 2'd0,
        LEN8 = 2'd1,
        LEN9 = 2'd2,
        LENX = 2'd3
    } char_len_e;

    typedef struct packed {
        logic mute;
        logic rx_ready;
        logic idle_flag;
    } mute_out_t;

    function automatic logic [TICK_W-1:0] frame_ticks(char_len_e len);
        case (len)
            LEN7:    return TICK_W'(9);
            LEN9:    return TICK_W'(11);
            default: return TICK_W'(10);
        endcase
    endfunction

    function automatic logic top_bit(logic [CHAR_W-1:0] d, char_len_e len);
        case (len)
            LEN7:    return d[6];
            LEN9:    return d[8];
            default: return d[7];
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] long_mask(char_len_e len);
        case (len)
            LEN7:    return 8'h3F;
            LEN9:    return 8'hFF;
            default: return 8'h7F;
        endcase
    endfunction

endpackage

// File: rtl/rx_addr_cmp.sv
module rx_addr_cmp
    import rx_mute_pkg::*;
(
    input  logic [CHAR_W-1:0] data,
    input  char_len_e         len,
    input  logic              long_sel,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              is_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        is_addr = top_bit(data, len);
        diff    = data[ADDR_W-1:0] ^ own_addr;
        if (long_sel)
            hit = (diff & long_mask(len)) == '0;
        else
            hit = diff[3:0] == 4'h0;
    end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_mute_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic              char_done,
    input  logic [TICK_W-1:0] frame_len,
    output logic              idle_pulse,
    output logic              line_quiet
);
    logic [TICK_W-1:0] cnt;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            armed      <= 1'b1;
            idle_pulse <= 1'b0;
            line_quiet <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (!rx_line) begin
                cnt        <= '0;
                line_quiet <= 1'b0;
            end else if (char_done) begin
                cnt        <= '0;
                armed      <= 1'b1;
                line_quiet <= 1'b0;
            end else if (armed && bit_tick) begin
                if (cnt == frame_len - TICK_W'(1)) begin
                    cnt        <= '0;
                    armed      <= 1'b0;
                    idle_pulse <= 1'b1;
                    line_quiet <= 1'b1;
                end else begin
                    cnt <= cnt + TICK_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rx_mute_fsm.sv
module rx_mute_fsm
    import rx_mute_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wake_mode_e mode,
    input  logic       char_valid,
    input  logic       is_addr,
    input  logic       hit,
    input  logic       idle_pulse,
    input  logic       line_quiet,
    input  logic       mute_req,
    output mute_out_t  q
);
    logic wake_ev, sleep_ev, deliver, flag;

    always_comb begin
        if (mode == WAKE_ON_ADDR) begin
            wake_ev  = char_valid && is_addr && hit;
            sleep_ev = mute_req || (char_valid && is_addr && !hit);
            deliver  = char_valid && (is_addr ? hit : !q.mute);
            flag     = idle_pulse;
        end else begin
            wake_ev  = idle_pulse && q.mute;
            sleep_ev = mute_req && !line_quiet;
            deliver  = char_valid && !q.mute;
            flag     = idle_pulse && !q.mute;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.rx_ready  <= deliver;
            q.idle_flag <= flag;
            if (wake_ev)
                q.mute <= 1'b0;
            else if (sleep_ev)
                q.mute <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_mute_ctrl.sv
module rx_mute_ctrl
    import rx_mute_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_sel,
    input  logic [1:0]        data_len,
    input  logic              addr_long,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mute_req,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    output logic              mute,
    output logic              rx_ready,
    output logic              idle_flag
);
    char_len_e  len;
    wake_mode_e mode;
    logic       addr_char, addr_hit, idle_pulse, line_quiet;
    mute_out_t  q;

    assign len  = char_len_e'(data_len);
    assign mode = wake_mode_e'(wake_sel);

    rx_addr_cmp u_cmp (
        .data     (char_data),
        .len      (len),
        .long_sel (addr_long),
        .own_addr (own_addr),
        .is_addr  (addr_char),
        .hit      (addr_hit)
    );

    rx_idle_timer u_idle (
        .clk        (clk),
        .rst        (rst),
        .rx_line    (rx_line),
        .bit_tick   (bit_tick),
        .char_done  (char_valid),
        .frame_len  (frame_ticks(len)),
        .idle_pulse (idle_pulse),
        .line_quiet (line_quiet)
    );

    rx_mute_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .char_valid (char_valid),
        .is_addr    (addr_char),
        .hit        (addr_hit),
        .idle_pulse (idle_pulse),
        .line_quiet (line_quiet),
        .mute_req   (mute_req),
        .q          (q)
    );

    assign mute      = q.mute;
    assign rx_ready  = q.rx_ready;
    assign idle_flag = q.idle_flag;
endmodule

// File: rtl/rx_mute_ctrl_chk.sv
module rx_mute_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic wake_sel,
    input logic mute_req,
    input logic char_valid,
    input logic addr_char,
    input logic addr_hit,
    input logic idle_pulse,
    input logic mute,
    input logic rx_ready,
    input logic idle_flag
);
    // R10: a character seen while muted in idle mode never produces a strobe
    p_muted_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (!wake_sel && char_valid && mute) |=> !rx_ready);

    // R8: a non-matching address mutes and is not delivered
    p_mismatch_mutes_r8: assert property (@(posedge clk) disable iff (rst)
        (wake_sel && char_valid && addr_char && !addr_hit) |=> (mute && !rx_ready));

    // R9 and R11: a matching address wakes and is delivered, mute request or not
    p_match_wakes_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_sel && char_valid && addr_char && addr_hit) |=> (!mute && rx_ready));

    // R3: an idle frame that ends mute is silent
    p_idle_wake_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (!wake_sel && idle_pulse && mute) |=> (!mute && !idle_flag));

    // R11: a mute request in address mode without a wakeup mutes
    p_req_mutes_r11: assert property (@(posedge clk) disable iff (rst)
        (wake_sel && mute_req && !(char_valid && addr_char)) |=> mute);

    // R3: idle flag only follows a detected idle frame
    p_flag_source_r3: assert property (@(posedge clk) disable iff (rst)
        idle_flag |-> $past(idle_pulse));
endmodule

bind rx_mute_ctrl rx_mute_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wake_sel   (wake_sel),
    .mute_req   (mute_req),
    .char_valid (char_valid),
    .addr_char  (addr_char),
    .addr_hit   (addr_hit),
    .idle_pulse (idle_pulse),
    .mute       (mute),
    .rx_ready   (rx_ready),
    .idle_flag  (idle_flag)
);

// File: tb/rx_mute_ctrl_tb.sv
`timescale 1ns/1ps
module rx_mute_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake_sel = 1'b0;
    logic [1:0] data_len = 2'd1;
    logic       addr_long = 1'b0;
    logic [7:0] own_addr = 8'h05;
    logic       mute_req = 1'b0;
    logic       rx_line = 1'b1;
    logic       bit_tick = 1'b0;
    logic       char_valid = 1'b0;
    logic [8:0] char_data = '0;
    logic       mute, rx_ready, idle_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_mute_ctrl u_dut (
        .clk(clk), .rst(rst), .wake_sel(wake_sel), .data_len(data_len),
        .addr_long(addr_long), .own_addr(own_addr), .mute_req(mute_req),
        .rx_line(rx_line), .bit_tick(bit_tick), .char_valid(char_valid),
        .char_data(char_data), .mute(mute), .rx_ready(rx_ready),
        .idle_flag(idle_flag)
    );

    // op: 0 = character, 1 = mute request
    typedef struct packed {
        logic       op;
        logic [8:0] d;
        logic       rdy;
        logic       mt;
    } vec_t;

    // address mode, 8-bit characters, short compare, own address 0x05
    localparam vec_t VECS [12] = '{
        '{1'b0, 9'h012, 1'b1, 1'b0},
        '{1'b0, 9'h083, 1'b0, 1'b1},
        '{1'b0, 9'h044, 1'b0, 1'b1},
        '{1'b0, 9'h0F5, 1'b1, 1'b0},
        '{1'b0, 9'h033, 1'b1, 1'b0},
        '{1'b1, 9'h000, 1'b0, 1'b1},
        '{1'b0, 9'h022, 1'b0, 1'b1},
        '{1'b0, 9'h085, 1'b1, 1'b0},
        '{1'b0, 9'h095, 1'b1, 1'b0},
        '{1'b0, 9'h105, 1'b1, 1'b0},
        '{1'b0, 9'h0A0, 1'b0, 1'b1},
        '{1'b0, 9'h1C5, 1'b1, 1'b0}
    };

    // bench model state
    bit m_mute, m_armed, m_quiet;

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mute_req = 0; char_valid = 0; bit_tick = 0; rx_line = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mute = 0; m_armed = 1; m_quiet = 0;
    endtask

    task automatic send_char(input logic [8:0] d, input logic req);
        @(negedge clk);
        char_valid = 1'b1; char_data = d; mute_req = req;
        @(negedge clk);
        char_valid = 1'b0; mute_req = 1'b0;
    endtask

    task automatic send_req();
        @(negedge clk);
        mute_req = 1'b1;
        @(negedge clk);
        mute_req = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1;
        end
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    function automatic int flen();
        return (data_len == 2'd0) ? 9 : (data_len == 2'd2) ? 11 : 10;
    endfunction

    function automatic bit m_is_addr(logic [8:0] d);
        return (data_len == 2'd0) ? d[6] : (data_len == 2'd2) ? d[8] : d[7];
    endfunction

    function automatic bit m_match(logic [8:0] d);
        if (!addr_long) return d[3:0] == own_addr[3:0];
        if (data_len == 2'd0) return d[5:0] == own_addr[5:0];
        if (data_len == 2'd2) return d[7:0] == own_addr[7:0];
        return d[6:0] == own_addr[6:0];
    endfunction

    task automatic model_run(input int n);
        for (int i = 0; i < n; i++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op <= 2) begin
                logic [8:0] d;
                bit a, h, er;
                d = 9'($urandom);
                if (op == 0) d = {1'b1, own_addr} | 9'h0C0;
                a = wake_sel && m_is_addr(d);
                h = m_match(d);
                er = a ? h : !m_mute;
                if (a) m_mute = !h;
                m_armed = 1; m_quiet = 0;
                send_char(d, 1'b0);
                chk(rx_ready, er, "R10 random strobe");
                chk(mute, m_mute, "R8 random mute");
            end else if (op == 3) begin
                if (wake_sel || !m_quiet) m_mute = 1;
                send_req();
                chk(mute, m_mute, "R2 random request");
            end else begin
                bit ef;
                ef = 0;
                if (m_armed) begin
                    ef = !(!wake_sel && m_mute);
                    if (!wake_sel) m_mute = 0;
                    m_armed = 0; m_quiet = 1;
                end
                ticks(flen());
                chk(idle_flag, ef, "R3 random idle flag");
                chk(mute, m_mute, "R3 random idle mute");
            end
        end
    endtask

    initial begin
        do_reset();
        chk(mute, 1'b0, "R1 mute after reset");
        chk(rx_ready, 1'b0, "R1 strobe after reset");
        chk(idle_flag, 1'b0, "R1 idle flag after reset");

        // table: address mode, 8-bit, short compare
        wake_sel = 1; data_len = 2'd1; addr_long = 0; own_addr = 8'h05;
        do_reset();
        foreach (VECS[i]) begin
            if (VECS[i].op) send_req();
            else send_char(VECS[i].d, 1'b0);
            chk(rx_ready, VECS[i].rdy, "R9 table strobe");
            chk(mute, VECS[i].mt, "R8 table mute");
        end

        // long compare, 7-bit characters, own 0x2A
        data_len = 2'd0; addr_long = 1; own_addr = 8'h2A;
        do_reset();
        send_char(9'h04A, 1'b0);
        chk(mute, 1'b1, "R7 len7 long mismatch");
        send_char(9'h0EA, 1'b0);
        chk(rx_ready, 1'b1, "R7 len7 long match (bit7 ignored)");
        chk(mute, 1'b0, "R6 len7 top bit 6");

        // long compare, 9-bit characters, own 0xA5
        data_len = 2'd2; own_addr = 8'hA5;
        do_reset();
        send_char(9'h0A5, 1'b0);
        chk(rx_ready, 1'b1, "R6 len9 bit8 clear is data");
        send_char(9'h1A4, 1'b0);
        chk(mute, 1'b1, "R7 len9 long mismatch");
        send_char(9'h1A5, 1'b0);
        chk(mute, 1'b0, "R7 len9 long match");

        // long compare 8-bit own 0x33: bit 6 differs
        data_len = 2'd1; own_addr = 8'h33;
        do_reset();
        send_char(9'h0F3, 1'b0);
        chk(mute, 1'b1, "R7 len8 long 7-bit compare");

        // priority: matching address and mute request together
        send_char(9'h0B3, 1'b1);
        chk(mute, 1'b0, "R11 wake beats request");
        chk(rx_ready, 1'b1, "R9 matching address delivered");
        send_req();
        chk(mute, 1'b1, "R11 request in address mode");

        // idle mode, 8-bit
        wake_sel = 0; data_len = 2'd1;
        do_reset();
        ticks(10);
        chk(idle_flag, 1'b1, "R5 start-up idle frame");
        send_req();
        chk(mute, 1'b0, "R4 request after idle ignored");
        send_char(9'h011, 1'b0);
        chk(rx_ready, 1'b1, "R10 data delivered unmuted");
        send_req();
        chk(mute, 1'b1, "R2 request mutes");
        send_char(9'h0FF, 1'b0);
        chk(rx_ready, 1'b0, "R10 data dropped muted");
        ticks(9);
        chk(idle_flag, 1'b0, "R5 one tick short");
        chk(mute, 1'b1, "R5 still muted");
        ticks(1);
        chk(mute, 1'b0, "R3 idle wakes");
        chk(idle_flag, 1'b0, "R3 wake idle silent");
        ticks(10);
        chk(idle_flag, 1'b0, "R5 no second idle without char");
        send_char(9'h022, 1'b0);
        ticks(10);
        chk(idle_flag, 1'b1, "R3 idle flag unmuted");

        // random sequences against the model
        for (int c = 0; c < 6; c++) begin
            wake_sel  = c[0];
            data_len  = 2'(c % 3);
            addr_long = c[1];
            own_addr  = 8'($urandom);
            do_reset();
            model_run(120);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule